// File: doc/BRIEF.md
# Conditional Jump Unit

This block looks at one 16-bit instruction word, decides whether it belongs to the jump format, and if so evaluates the condition that the word selects against the processor's four status flags: negative, zero, carry and overflow. It also works out the program counter the core should use next. When the jump is taken, that is the incoming PC plus a byte displacement of twice the signed word offset carried in the instruction. In every other case it is the incoming PC, which already points past the jump word.

The unit sits between decode and fetch. Every cycle it takes the word, the PC and the flags, and it returns the three results registered one clock later. It holds no other state.

Top module: `jmp_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values of `is_jump`, `taken` and `next_pc` are 0, 0 and 16'h0000.
- R2: `is_jump` is 1 exactly when instruction bits [15:13] equal 3'b001, which means the top nibble is 2 or 3.
- R3: With bits [12:10] = 3'b000 the jump is taken when Z is 0. With 3'b001 it is taken when Z is 1.
- R4: With bits [12:10] = 3'b010 the jump is taken when C is 0 (unsigned lower). With 3'b011 it is taken when C is 1 (unsigned higher-or-same).
- R5: With bits [12:10] = 3'b100 the jump is taken when N is 1.
- R6: With bits [12:10] = 3'b101 the jump is taken when N equals V (signed greater-or-equal). With 3'b110 it is taken when N differs from V (signed less).
- R7: With bits [12:10] = 3'b111 the jump is always taken.
- R8: When taken, `next_pc` equals `pc_in` plus bits [9:0] read as a two's-complement value in -512..511, multiplied by 2 and sign-extended to 16 bits, with the sum wrapping modulo 2^16 (reach -1024..+1022 bytes).
- R9: When not taken, `next_pc` equals `pc_in`.
- R10: `taken` is never 1 while `is_jump` is 0. A word that is not a jump ignores its condition field and the flags.
- R11: All three outputs reflect the inputs sampled at the previous rising edge. Between edges they hold steady when the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word under test |
| pc_in | input | 16 | Program counter already advanced past the word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| is_jump | output | 1 | Word has the jump format |
| taken | output | 1 | Jump condition met |
| next_pc | output | 16 | Program counter to use next |

## Verification
All three results come from a single output register. A word, PC and flag set driven before a rising edge therefore shows up at the ports just after that edge, one cycle of latency for every result. The bench changes inputs on the falling edge and reads the previous vector's results just after that, before the next rising edge, which also shows the outputs have not moved yet. It then reads the new results on the following falling edge. The sweep covers every opcode field, every condition code and every flag combination, across offsets at both range ends and PCs that wrap.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned OFFS_W = 10;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned OPC_W  = 3;
    localparam int unsigned NCOND  = 1 << SEL_W;

    localparam logic [OPC_W-1:0] JMP_OPC = 3'b001;

    typedef enum logic [SEL_W-1:0] {
        C_ZCLR  = 3'd0,
        C_ZSET  = 3'd1,
        C_CCLR  = 3'd2,
        C_CSET  = 3'd3,
        C_NSET  = 3'd4,
        C_SGE   = 3'd5,
        C_SLT   = 3'd6,
        C_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              is_jump;
        cond_e             cond;
        logic [OFFS_W-1:0] offs;
    } jdec_t;

    typedef struct packed {
        logic              is_jump;
        logic              taken;
        logic [WORD_W-1:0] npc;
    } jres_t;

    // Word offset -> sign-extended byte displacement
    function automatic logic [WORD_W-1:0] byte_disp(input logic [OFFS_W-1:0] offs);
        return {{(WORD_W-OFFS_W-1){offs[OFFS_W-1]}}, offs, 1'b0};
    endfunction

    function automatic logic cond_holds(input cond_e sel, input flags_t f);
        logic r;
        case (sel)
            C_ZCLR:   r = ~f.z;
            C_ZSET:   r =  f.z;
            C_CCLR:   r = ~f.c;
            C_CSET:   r =  f.c;
            C_NSET:   r =  f.n;
            C_SGE:    r = ~(f.n ^ f.v);
            C_SLT:    r =  (f.n ^ f.v);
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
    import jmp_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned OW = OFFS_W,
    parameter int unsigned SW = SEL_W,
    parameter int unsigned PW = OPC_W
) (
    input  logic [W-1:0] word,
    output jdec_t        dec
);
    localparam int unsigned OPC_LSB = W - PW;
    localparam int unsigned SEL_LSB = OW;

    always_comb begin
        dec.is_jump = (word[W-1:OPC_LSB] == JMP_OPC);
        dec.cond    = cond_e'(word[SEL_LSB +: SW]);
        dec.offs    = word[OW-1:0];
    end
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_pkg::*;
#(
    parameter int unsigned SW = SEL_W
) (
    input  cond_e  sel,
    input  flags_t flags,
    output logic   hold
);
    localparam int unsigned N = 1 << SW;

    logic [N-1:0] hit;

    for (genvar k = 0; k < N; k++) begin : g_cond
        assign hit[k] = cond_holds(cond_e'(k), flags);
    end

    assign hold = hit[sel];
endmodule

// File: rtl/jmp_target.sv
module jmp_target
    import jmp_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned OW = OFFS_W
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] offs,
    input  logic          take,
    output logic [W-1:0]  npc
);
    logic [W-1:0] dest;

    assign dest = pc + byte_disp(offs);
    assign npc  = take ? dest : pc;
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
    import jmp_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned OW = OFFS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] pc_in,
    input  logic         flag_n,
    input  logic         flag_z,
    input  logic         flag_c,
    input  logic         flag_v,
    output logic         is_jump,
    output logic         taken,
    output logic [W-1:0] next_pc
);
    jdec_t        dec;
    flags_t       fl;
    logic         hold;
    logic         take;
    logic [W-1:0] npc;
    jres_t        res_q;

    assign fl = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

    jmp_decode #(.W(W), .OW(OW)) u_dec (
        .word (instr),
        .dec  (dec)
    );

    jmp_cond_eval u_eval (
        .sel   (dec.cond),
        .flags (fl),
        .hold  (hold)
    );

    assign take = dec.is_jump & hold;

    jmp_target #(.W(W), .OW(OW)) u_tgt (
        .pc   (pc_in),
        .offs (dec.offs),
        .take (take),
        .npc  (npc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.is_jump <= dec.is_jump;
            res_q.taken   <= take;
            res_q.npc     <= npc;
        end
    end

    assign is_jump = res_q.is_jump;
    assign taken   = res_q.taken;
    assign next_pc = res_q.npc;
endmodule

// File: rtl/jmp_unit_chk.sv
module jmp_unit_chk
    import jmp_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned OW = OFFS_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] instr,
    input logic [W-1:0] pc_in,
    input logic         is_jump,
    input logic         taken,
    input logic [W-1:0] next_pc
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!is_jump && !taken && next_pc == '0));

    assert_format_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (is_jump == ($past(instr[W-1:W-OPC_W]) == JMP_OPC)));

    assert_always_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (instr[W-1:OW] == {JMP_OPC, C_ALWAYS}) |=> taken);

    assert_target_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!taken || next_pc == $past(pc_in) + byte_disp($past(instr[OW-1:0]))));

    assert_fallthru_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (taken || next_pc == $past(pc_in)));

    assert_nojump_notaken_R10: assert property (@(posedge clk) disable iff (rst)
        !is_jump |-> !taken);
endmodule

bind jmp_unit jmp_unit_chk #(.W(W), .OW(OW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .instr   (instr),
    .pc_in   (pc_in),
    .is_jump (is_jump),
    .taken   (taken),
    .next_pc (next_pc)
);

// File: tb/tb_jmp_unit.sv
module tb_jmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr;
    logic [15:0] pc_in;
    logic        flag_n, flag_z, flag_c, flag_v;
    logic        is_jump, taken;
    logic [15:0] next_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    jmp_unit dut (
        .clk     (clk),
        .rst     (rst),
        .instr   (instr),
        .pc_in   (pc_in),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .flag_v  (flag_v),
        .is_jump (is_jump),
        .taken   (taken),
        .next_pc (next_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_cond(input int sel, input bit n, input bit z, input bit c, input bit v);
        case (sel)
            0: return !z;
            1: return z;
            2: return !c;
            3: return c;
            4: return n;
            5: return n == v;
            6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string cond_req(input int sel);
        case (sel)
            0, 1: return "R3";
            2, 3: return "R4";
            4:    return "R5";
            5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [9:0]  offs_tab [5];
        logic [15:0] pc_tab   [5];
        bit          pv_j, pv_t;
        logic [15:0] pv_pc;

        offs_tab[0] = 10'h000; pc_tab[0] = 16'h1234;
        offs_tab[1] = 10'h001; pc_tab[1] = 16'hFFFE;
        offs_tab[2] = 10'h3FF; pc_tab[2] = 16'h0000;
        offs_tab[3] = 10'h1FF; pc_tab[3] = 16'h8000;
        offs_tab[4] = 10'h200; pc_tab[4] = 16'h0100;

        rst = 1'b1;
        instr = 16'h3C05; pc_in = 16'hABCD;
        {flag_n, flag_z, flag_c, flag_v} = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs cleared despite a taken-looking input
        chk(is_jump == 1'b0, "R1 is_jump", {15'd0, is_jump}, 16'h0);
        chk(taken == 1'b0,   "R1 taken",   {15'd0, taken},   16'h0);
        chk(next_pc == 16'h0, "R1 next_pc", next_pc, 16'h0);
        rst = 1'b0;
        pv_j = 1'b0; pv_t = 1'b0; pv_pc = 16'h0;

        for (int op = 0; op < 8; op++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int k = 0; k < 5; k++) begin
                        bit          e_j, e_t;
                        int          so;
                        logic [15:0] e_pc;
                        instr = {3'(op), 3'(sel), offs_tab[k]};
                        pc_in = pc_tab[k];
                        {flag_n, flag_z, flag_c, flag_v} = 4'(f);
                        #1;
                        // R11: outputs still show the previous vector before the edge
                        if (k == 0 && f == 0) begin
                            chk(is_jump == pv_j && taken == pv_t && next_pc == pv_pc,
                                "R11 hold", next_pc, pv_pc);
                        end
                        e_j = (op == 1);
                        e_t = e_j && exp_cond(sel, flag_n, flag_z, flag_c, flag_v);
                        so  = (offs_tab[k] >= 10'd512) ? int'(offs_tab[k]) - 1024 : int'(offs_tab[k]);
                        e_pc = e_t ? 16'(int'(pc_tab[k]) + 2 * so) : pc_tab[k];
                        @(negedge clk);
                        chk(is_jump == e_j, "R2 is_jump", {15'd0, is_jump}, {15'd0, e_j});
                        if (e_j)
                            chk(taken == e_t, cond_req(sel), {15'd0, taken}, {15'd0, e_t});
                        else
                            chk(taken == 1'b0, "R10 taken on non-jump", {15'd0, taken}, 16'h0);
                        chk(next_pc == e_pc, e_t ? "R8 target" : "R9 fallthrough", next_pc, e_pc);
                        pv_j = e_j; pv_t = e_t; pv_pc = e_pc;
                    end
                end
            end
        end

        // R1: reset applied mid-stream clears outputs again
        rst = 1'b1;
        @(negedge clk);
        chk(!is_jump && !taken && next_pc == 16'h0, "R1 re-reset", next_pc, 16'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule